// File: doc/BRIEF.md
# Phase-Frequency Detector with Tri-State and Powerdown Control

This block compares a divided reference clock against a divided feedback clock and turns the phase difference into pump-up and pump-down requests for a charge pump. Both inputs are level signals in the block's system clock domain. A rising edge on either input sets that input's detector flop. When both flops are set, they are cleared together one clock later. A leading input therefore holds its request for the lag plus two cycles, and a locked loop shows only two-cycle pulses on both requests.

A polarity input sets which request follows which input, to suit the slope of the oscillator being tuned. A tri-state input drives the pump output-enable low and forces both requests low. The detector and the lock monitor keep running while the tri-state input is high.

A powerdown strobe with a value bit controls powerdown. If the tri-state input is high when powerdown is loaded, the block powers down at once. Otherwise a pending state waits until neither detector flop is set, and only then powers down. Loading a zero wakes the block at once. A lock flag rises after eight consecutive clean compare cycles.

Top module: `pfd_tristate_top`

## Requirements
- R1: After reset, both pump requests, the lock flag, the pending flag and the powerdown flag are 0, and the output-enable equals the inverse of the tri-state input.
- R2: With polarity 1, tri-state 0 and powerdown off, a reference edge that leads the feedback edge by d cycles (d >= 1) gives an up pulse d+2 cycles wide and a down pulse 2 cycles wide. A feedback lead of d cycles gives the mirror image.
- R3: With polarity 0, the up and down widths of R2 are exchanged.
- R4: Edges that arrive in the same cycle give up and down pulses that are each exactly 2 cycles wide.
- R5: While the tri-state input is 1, the output-enable is 0 and both requests are 0. Detection and lock tracking continue.
- R6: A powerdown load with value 1 while tri-state is 0 sets the pending flag. The powerdown flag rises only once neither detector flop is set; while a request is still active, powerdown stays off.
- R7: A powerdown load with value 1 while tri-state is 1 sets the powerdown flag in the next cycle, even when a request is active.
- R8: While powered down, input edges are ignored: requests are 0, the output-enable is 0 and the lock flag is 0.
- R9: A powerdown load with value 0 clears both the powerdown and pending flags in the next cycle, and detection resumes.
- R10: The lock flag is 1 once 8 consecutive compare cycles have completed with no request high for more than 2 cycles, and it is 0 after only 7.
- R11: The lock flag and the clean-cycle count drop to 0 as soon as any request stays high for 3 or more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Divided reference clock (level) |
| fb_i | input | 1 | Divided feedback clock (level) |
| pol_pos_i | input | 1 | 1: positive oscillator slope, up follows reference |
| tristate_i | input | 1 | Forces the pump output to high impedance |
| pd_load_i | input | 1 | Strobe that loads the powerdown value |
| pd_val_i | input | 1 | Powerdown value loaded by the strobe |
| pump_up_o | output | 1 | Pump-up request |
| pump_dn_o | output | 1 | Pump-down request |
| pump_oe_o | output | 1 | Pump output-enable (0 = high impedance) |
| lock_o | output | 1 | Lock indication |
| pd_pend_o | output | 1 | Synchronous powerdown waiting for pump idle |
| pd_active_o | output | 1 | Block is powered down |

## Verification
Several properties are checked on every cycle:
- requests stay low whenever the output-enable is low;
- an asynchronous powerdown takes effect one cycle after its load;
- a wake-up load clears both powerdown flags;
- a pending powerdown never completes while a request is visible;
- the lock flag is cleared during powerdown.

Pulse widths as a function of edge lead and polarity, the eight-compare lock threshold, and the lock drop on a wide pulse cannot be checked cycle by cycle. Only the bench's scenarios show them: a sweep of edge offsets under both polarities, and directed powerdown and lock sequences.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_WAIT = 2'd1,
        PWR_DOWN = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;
    localparam int unsigned N_CH   = 2;

    function automatic pump_req_t map_polarity(input logic pol_pos,
                                               input logic ref_set,
                                               input logic fb_set);
        pump_req_t r;
        r.up = pol_pos ? ref_set : fb_set;
        r.dn = pol_pos ? fb_set  : ref_set;
        return r;
    endfunction

endpackage

// File: rtl/pfd_rise.sv
module pfd_rise #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b0;
            else     prev_q[g] <= sig_i[g];
        end
        assign rise_o[g] = sig_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/pfd_flops.sv
module pfd_flops
    import pfd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hold_i,
    input  logic [N_CH-1:0] rise_i,
    output logic [N_CH-1:0] set_o,
    output logic            cmp_o
);
    logic [N_CH-1:0] set_q;
    logic            clr_q;
    logic            cmp_q;

    // Clear is registered once after both flops are set: minimum pulse of 2 cycles.
    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            clr_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            clr_q <= (&set_q) & ~clr_q;
            cmp_q <= clr_q;
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ff
        always_ff @(posedge clk) begin
            if (rst || hold_i)  set_q[g] <= 1'b0;
            else if (clr_q)     set_q[g] <= rise_i[g];
            else                set_q[g] <= set_q[g] | rise_i[g];
        end
    end

    assign set_o = set_q;
    assign cmp_o = cmp_q;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon
    import pfd_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 8,
    parameter int unsigned MAX_WIDTH   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold_i,
    input  logic [N_CH-1:0] busy_i,
    input  logic            cmp_i,
    output logic            lock_o
);
    localparam int unsigned WSAT = MAX_WIDTH + 1;
    localparam int unsigned WW   = $clog2(WSAT + 1);
    localparam int unsigned CW   = $clog2(LOCK_CYCLES + 1);

    logic [WW-1:0]   width_q [N_CH];
    logic [N_CH-1:0] too_wide;
    logic [CW-1:0]   good_q;

    for (genvar g = 0; g < N_CH; g++) begin : g_w
        always_ff @(posedge clk) begin
            if (rst || hold_i)
                width_q[g] <= '0;
            else if (!busy_i[g])
                width_q[g] <= '0;
            else if (width_q[g] != WW'(WSAT))
                width_q[g] <= width_q[g] + 1'b1;
        end
        assign too_wide[g] = (width_q[g] > WW'(MAX_WIDTH));
    end

    always_ff @(posedge clk) begin
        if (rst || hold_i)
            good_q <= '0;
        else if (|too_wide)
            good_q <= '0;
        else if (cmp_i && good_q != CW'(LOCK_CYCLES))
            good_q <= good_q + 1'b1;
    end

    assign lock_o = (good_q == CW'(LOCK_CYCLES));
endmodule

// File: rtl/pfd_pwr_ctl.sv
module pfd_pwr_ctl
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic val_i,
    input  logic tristate_i,
    input  logic busy_i,
    output logic pending_o,
    output logic down_o
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            if (!val_i)
                state_d = PWR_RUN;
            else if (tristate_i || state_q == PWR_DOWN)
                state_d = PWR_DOWN;
            else
                state_d = PWR_WAIT;
        end else if (state_q == PWR_WAIT && !busy_i) begin
            state_d = PWR_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PWR_RUN;
        else     state_q <= state_d;
    end

    assign pending_o = (state_q == PWR_WAIT);
    assign down_o    = (state_q == PWR_DOWN);
endmodule

// File: rtl/pfd_tristate_top.sv
module pfd_tristate_top
    import pfd_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 8,
    parameter int unsigned MAX_WIDTH   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    input  logic fb_i,
    input  logic pol_pos_i,
    input  logic tristate_i,
    input  logic pd_load_i,
    input  logic pd_val_i,
    output logic pump_up_o,
    output logic pump_dn_o,
    output logic pump_oe_o,
    output logic lock_o,
    output logic pd_pend_o,
    output logic pd_active_o
);
    logic [N_CH-1:0] lvl;
    logic [N_CH-1:0] rise;
    logic [N_CH-1:0] set_q;
    logic            cmp;
    logic            down;
    pump_req_t       req;

    assign lvl[CH_REF] = ref_i;
    assign lvl[CH_FB]  = fb_i;

    pfd_rise #(.W(N_CH)) u_rise (
        .clk(clk), .rst(rst), .sig_i(lvl), .rise_o(rise)
    );

    pfd_flops u_flops (
        .clk(clk), .rst(rst), .hold_i(down),
        .rise_i(rise), .set_o(set_q), .cmp_o(cmp)
    );

    pfd_lock_mon #(.LOCK_CYCLES(LOCK_CYCLES), .MAX_WIDTH(MAX_WIDTH)) u_lock (
        .clk(clk), .rst(rst), .hold_i(down),
        .busy_i(set_q), .cmp_i(cmp), .lock_o(lock_o)
    );

    pfd_pwr_ctl u_pwr (
        .clk(clk), .rst(rst), .load_i(pd_load_i), .val_i(pd_val_i),
        .tristate_i(tristate_i), .busy_i(|set_q),
        .pending_o(pd_pend_o), .down_o(down)
    );

    assign req         = map_polarity(pol_pos_i, set_q[CH_REF], set_q[CH_FB]);
    assign pump_oe_o   = ~tristate_i & ~down;
    assign pump_up_o   = pump_oe_o & req.up;
    assign pump_dn_o   = pump_oe_o & req.dn;
    assign pd_active_o = down;
endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
    input logic clk,
    input logic rst,
    input logic ref_i,
    input logic fb_i,
    input logic pol_pos_i,
    input logic tristate_i,
    input logic pd_load_i,
    input logic pd_val_i,
    input logic pump_up_o,
    input logic pump_dn_o,
    input logic pump_oe_o,
    input logic lock_o,
    input logic pd_pend_o,
    input logic pd_active_o
);
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !pump_oe_o |-> (!pump_up_o && !pump_dn_o));

    p_async_down_r7: assert property (@(posedge clk) disable iff (rst)
        (pd_load_i && pd_val_i && tristate_i) |=> (pd_active_o && !pd_pend_o));

    p_wake_r9: assert property (@(posedge clk) disable iff (rst)
        (pd_load_i && !pd_val_i) |=> (!pd_active_o && !pd_pend_o));

    p_wait_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (pd_pend_o && (pump_up_o || pump_dn_o) && !pd_load_i) |=> !pd_active_o);

    p_down_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        pd_active_o |-> !pump_oe_o);

    p_down_unlock_r8: assert property (@(posedge clk) disable iff (rst)
        pd_active_o |=> !lock_o);
endmodule

bind pfd_tristate_top pfd_tristate_chk chk_i (.*);

// File: tb/pfd_tristate_top_tb.sv
module pfd_tristate_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_i = 1'b0, fb_i = 1'b0, pol_pos_i = 1'b1, tristate_i = 1'b0;
    logic pd_load_i = 1'b0, pd_val_i = 1'b0;
    logic pump_up_o, pump_dn_o, pump_oe_o, lock_o, pd_pend_o, pd_active_o;

    int n_chk = 0;
    int n_fail = 0;
    int up_w, dn_w;

    always #4 clk = ~clk;

    pfd_tristate_top dut_i (.*);

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // Fire a reference edge at cycle dr and a feedback edge at cycle df, counting request widths.
    task automatic fire(input int dr, input int df);
        up_w = 0;
        dn_w = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            up_w += int'(pump_up_o);
            dn_w += int'(pump_dn_o);
            ref_i = (i >= dr) && (i < dr + 3);
            fb_i  = (i >= df) && (i < df + 3);
        end
        @(negedge clk);
        ref_i = 1'b0;
        fb_i  = 1'b0;
    endtask

    task automatic pd_load(input logic v);
        @(negedge clk);
        pd_load_i = 1'b1;
        pd_val_i  = v;
        @(negedge clk);
        pd_load_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 up", pump_up_o, 0);
        chk_eq("R1 dn", pump_dn_o, 0);
        chk_eq("R1 lock", lock_o, 0);
        chk_eq("R1 pend", pd_pend_o, 0);
        chk_eq("R1 down", pd_active_o, 0);
        chk_eq("R1 oe", pump_oe_o, 1);

        // R2 R3 R4 sweep over edge offset and polarity
        for (int p = 0; p < 2; p++) begin
            pol_pos_i = p[0];
            for (int d = -5; d <= 5; d++) begin
                int e_ref, e_fb;
                e_ref = (d > 0) ? d + 2 : 2;
                e_fb  = (d < 0) ? -d + 2 : 2;
                fire(6, 6 + d);
                if (d == 0) begin
                    chk_eq("R4 up aligned", up_w, 2);
                    chk_eq("R4 dn aligned", dn_w, 2);
                end else if (p == 1) begin
                    chk_eq("R2 up width", up_w, e_ref);
                    chk_eq("R2 dn width", dn_w, e_fb);
                end else begin
                    chk_eq("R3 up width", up_w, e_fb);
                    chk_eq("R3 dn width", dn_w, e_ref);
                end
            end
        end
        pol_pos_i = 1'b1;

        // R10 lock after 8 clean compares, not after 7
        fire(2, 6);
        for (int k = 0; k < 7; k++) fire(4, 4);
        chk_eq("R10 lock after 7", lock_o, 0);
        fire(4, 4);
        chk_eq("R10 lock after 8", lock_o, 1);

        // R11 wide pulse drops lock
        fire(2, 6);
        chk_eq("R11 lock dropped", lock_o, 0);

        // R5 tri-state: outputs quiet, loop still tracks lock
        tristate_i = 1'b1;
        fire(2, 4);
        chk_eq("R5 up quiet", up_w, 0);
        chk_eq("R5 dn quiet", dn_w, 0);
        chk_eq("R5 oe", pump_oe_o, 0);
        for (int k = 0; k < 8; k++) fire(4, 4);
        chk_eq("R5 lock under tristate", lock_o, 1);
        tristate_i = 1'b0;
        @(negedge clk);

        // R6 synchronous powerdown waits for idle
        @(negedge clk); ref_i = 1'b1;
        @(negedge clk); ref_i = 1'b0;
        pd_load(1'b1);
        chk_eq("R6 pending set", pd_pend_o, 1);
        chk_eq("R6 not down yet", pd_active_o, 0);
        repeat (5) @(negedge clk);
        chk_eq("R6 still pending", pd_pend_o, 1);
        chk_eq("R6 up still on", pump_up_o, 1);
        fb_i = 1'b1;
        @(negedge clk); fb_i = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R6 down after idle", pd_active_o, 1);
        chk_eq("R6 pending cleared", pd_pend_o, 0);
        chk_eq("R6 oe off", pump_oe_o, 0);

        // R8 edges ignored while down
        fire(2, 5);
        chk_eq("R8 up ignored", up_w, 0);
        chk_eq("R8 dn ignored", dn_w, 0);
        chk_eq("R8 lock low", lock_o, 0);

        // R9 wake-up
        pd_load(1'b0);
        chk_eq("R9 down cleared", pd_active_o, 0);
        chk_eq("R9 oe back", pump_oe_o, 1);
        fire(2, 4);
        chk_eq("R9 up resumes", up_w, 4);
        chk_eq("R9 dn resumes", dn_w, 2);

        // R7 asynchronous powerdown while a request is active
        @(negedge clk); ref_i = 1'b1;
        @(negedge clk); ref_i = 1'b0;
        tristate_i = 1'b1;
        pd_load(1'b1);
        chk_eq("R7 down at once", pd_active_o, 1);
        chk_eq("R7 no pending", pd_pend_o, 0);
        tristate_i = 1'b0;
        pd_load(1'b0);
        chk_eq("R7 wake", pd_active_o, 0);
        chk_eq("R7 idle after wake", pump_up_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule